// File: doc/BRIEF.md
# PTP time-of-day counter

This block keeps a hardware time of day for precision time stamping. The running time is a 32-bit seconds count plus a 31-bit sub-second count. The sub-second count advances by a programmable step. In coarse mode it steps on every clock. In fine mode it steps only on the clocks where a 32-bit accumulator, fed with a software-trimmed addend, carries out. This lets software tune the effective tick rate without touching the step size.

Software drives the block through a small word-addressed register port. It can load an absolute time, apply a signed offset, or install a new addend. Each of these commands is started by a control bit that clears itself once the action is done. The sub-second field wraps either at one billion, so it counts nanoseconds, or at 2^31, so it counts binary fractions of a second. Either wrap carries into the seconds count. The live time also drives two output buses for timestamp consumers.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset, seconds, sub-seconds, accumulator, addend, step and all update registers are zero, and the control register reads 0 (decimal wrap, coarse mode, no pending command).
- R2: Writing address 0 with bit 0 set loads the seconds-update register (address 2) and bits 30:0 of the sub-update register (address 3) into the time on the next clock. No step is added on that clock. Bit 0 reads back as 1 for exactly one cycle, then as 0.
- R3: Writing address 0 with bit 1 set adds the update registers to the time on the next clock. The sub-second sum wraps at the rollover value with a carry into seconds. Seconds are the modulo-2^32 sum of the old seconds, the seconds-update value and the carry.
- R4: Bit 31 of the sub-update register marks a subtraction. Software writes the rollover value minus the magnitude in bits 30:0, and 2^32 minus the seconds in address 2. The block then also subtracts 1 from the seconds sum, so the result equals the old time minus the offset, including a borrow.
- R5: Writing address 0 with bit 2 set copies the addend-update register (address 4) into the active addend (read at address 7) on the next clock. The bit then self-clears.
- R6: When init and update are requested in the same write, only init takes effect. An addend request in the same write is applied on the same clock.
- R7: In coarse mode (control bit 3 = 0), the step register (address 1, bits 30:0) is added to the sub-seconds on every clock that has no time command.
- R8: Control bit 4 = 0 selects a wrap at 1,000,000,000. Control bit 4 = 1 selects a wrap at 2^31. Either wrap subtracts the rollover value and adds 1 to the seconds, which wrap modulo 2^32.
- R9: In fine mode (control bit 3 = 1), the accumulator adds the active addend on every clock. The step is applied only on clocks where that addition carries out of 32 bits. An addend of 0 freezes the time.
- R10: Reads are combinational. Address 6 returns the live sub-seconds, and a read strobe there copies the live seconds into a shadow. Address 5 returns the shadow. Addresses 1 to 4 return the written values, with the subtract flag in bit 31 of address 3.
- R11: The sub-second field stays below the selected rollover value at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe (latches seconds shadow at address 6) |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Combinational read data |
| sec_o | output | 32 | Live seconds |
| sub_o | output | 31 | Live sub-seconds |

## Verification
The range checks assume that software keeps every sub-second value it writes (step, load value, offset magnitude) below the active rollover value. They also assume it never switches from binary to decimal wrap while the live sub-seconds are at or above one billion. The stimulus runs all decimal-mode cases first and moves to binary mode only afterwards. All of its load values, offsets and steps are chosen below the rollover of the mode in force.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  typedef enum logic [2:0] {
    A_CTRL    = 3'd0,
    A_INCR    = 3'd1,
    A_SEC_UPD = 3'd2,
    A_SUB_UPD = 3'd3,
    A_ADD_UPD = 3'd4,
    A_SEC     = 3'd5,
    A_SUB     = 3'd6,
    A_ADDEND  = 3'd7
  } reg_addr_e;

  localparam int unsigned C_INIT   = 0;
  localparam int unsigned C_UPDATE = 1;
  localparam int unsigned C_ADDEND = 2;
  localparam int unsigned C_FINE   = 3;
  localparam int unsigned C_BINARY = 4;

  typedef struct packed {
    logic addend;
    logic update;
    logic init;
  } cmd_t;
endpackage

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
  import ptp_tod_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned SUB_W  = 31,
  parameter int unsigned ACC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [ACC_W-1:0]  addend_i,
  output cmd_t              cmd_o,
  output logic              fine_o,
  output logic              binary_o,
  output logic [SUB_W-1:0]  incr_o,
  output logic [SEC_W-1:0]  sec_upd_o,
  output logic [SUB_W-1:0]  sub_upd_o,
  output logic              neg_o,
  output logic [ACC_W-1:0]  add_upd_o
);
  logic [SEC_W-1:0] shadow_q;
  logic             wr_ctrl;

  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o     <= '0;
      fine_o    <= 1'b0;
      binary_o  <= 1'b0;
      incr_o    <= '0;
      sec_upd_o <= '0;
      sub_upd_o <= '0;
      neg_o     <= 1'b0;
      add_upd_o <= '0;
      shadow_q  <= '0;
    end else begin
      // pending commands live for exactly one cycle
      cmd_o <= wr_ctrl ? cmd_t'(wr_data_i[C_ADDEND:C_INIT]) : '0;
      if (wr_ctrl) begin
        fine_o   <= wr_data_i[C_FINE];
        binary_o <= wr_data_i[C_BINARY];
      end
      if (wr_en_i) begin
        unique case (wr_addr_i)
          A_INCR:    incr_o    <= wr_data_i[SUB_W-1:0];
          A_SEC_UPD: sec_upd_o <= wr_data_i[SEC_W-1:0];
          A_SUB_UPD: begin
            sub_upd_o <= wr_data_i[SUB_W-1:0];
            neg_o     <= wr_data_i[DATA_W-1];
          end
          A_ADD_UPD: add_upd_o <= wr_data_i[ACC_W-1:0];
          default: ;
        endcase
      end
      if (rd_en_i && (rd_addr_i == A_SUB)) shadow_q <= sec_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[C_INIT]   = cmd_o.init;
        rd_data_o[C_UPDATE] = cmd_o.update;
        rd_data_o[C_ADDEND] = cmd_o.addend;
        rd_data_o[C_FINE]   = fine_o;
        rd_data_o[C_BINARY] = binary_o;
      end
      A_INCR:    rd_data_o = DATA_W'(incr_o);
      A_SEC_UPD: rd_data_o = DATA_W'(sec_upd_o);
      A_SUB_UPD: begin
        rd_data_o[SUB_W-1:0]  = sub_upd_o;
        rd_data_o[DATA_W-1]   = neg_o;
      end
      A_ADD_UPD: rd_data_o = DATA_W'(add_upd_o);
      A_SEC:     rd_data_o = DATA_W'(shadow_q);
      A_SUB:     rd_data_o = DATA_W'(sub_i);
      default:   rd_data_o = DATA_W'(addend_i);
    endcase
  end
endmodule

// File: rtl/ptp_tod_rate.sv
module ptp_tod_rate #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fine_i,
  input  logic             load_i,
  input  logic [ACC_W-1:0] add_upd_i,
  output logic [ACC_W-1:0] addend_o,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, addend_o};
  assign tick_o = fine_i ? sum[ACC_W] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      addend_o <= '0;
    end else begin
      acc_q <= sum[ACC_W-1:0];
      if (load_i) addend_o <= add_upd_i;
    end
  end
endmodule

// File: rtl/ptp_tod_time.sv
module ptp_tod_time #(
  parameter int unsigned SEC_W    = 32,
  parameter int unsigned SUB_W    = 31,
  parameter int unsigned DEC_ROLL = 1_000_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             binary_i,
  input  logic             tick_i,
  input  logic             init_i,
  input  logic             update_i,
  input  logic             neg_i,
  input  logic [SEC_W-1:0] sec_upd_i,
  input  logic [SUB_W-1:0] sub_upd_i,
  input  logic [SUB_W-1:0] incr_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o
);
  localparam logic [SUB_W:0] BIN_R = {1'b1, {SUB_W{1'b0}}};
  localparam logic [SUB_W:0] DEC_R = (SUB_W+1)'(DEC_ROLL);

  logic [SUB_W:0]   roll, sum, wrapped;
  logic [SUB_W-1:0] step;
  logic             wrap;
  logic [SEC_W-1:0] sec_add, sec_next;

  always_comb begin
    roll     = binary_i ? BIN_R : DEC_R;
    step     = update_i ? sub_upd_i : incr_i;
    sum      = {1'b0, sub_o} + {1'b0, step};
    wrap     = (sum >= roll);
    wrapped  = wrap ? (sum - roll) : sum;
    sec_add  = update_i ? sec_upd_i : '0;
    // subtract flag removes the carry implied by the complement encoding
    sec_next = sec_o + sec_add + SEC_W'(wrap) - SEC_W'(update_i & neg_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_o <= '0;
      sub_o <= '0;
    end else if (init_i) begin
      sec_o <= sec_upd_i;
      sub_o <= sub_upd_i;
    end else if (update_i || tick_i) begin
      sec_o <= sec_next;
      sub_o <= wrapped[SUB_W-1:0];
    end
  end
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SEC_W    = 32,
  parameter int unsigned SUB_W    = 31,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned DEC_ROLL = 1_000_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic [SUB_W-1:0]  sub_o
);
  cmd_t             cmd;
  logic             fine, binary, neg, tick;
  logic [SUB_W-1:0] incr, sub_upd;
  logic [SEC_W-1:0] sec_upd;
  logic [ACC_W-1:0] add_upd, addend;

  ptp_tod_regs #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .SUB_W(SUB_W), .ACC_W(ACC_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .sec_i     (sec_o),
    .sub_i     (sub_o),
    .addend_i  (addend),
    .cmd_o     (cmd),
    .fine_o    (fine),
    .binary_o  (binary),
    .incr_o    (incr),
    .sec_upd_o (sec_upd),
    .sub_upd_o (sub_upd),
    .neg_o     (neg),
    .add_upd_o (add_upd)
  );

  ptp_tod_rate #(.ACC_W(ACC_W)) u_rate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fine_i    (fine),
    .load_i    (cmd.addend),
    .add_upd_i (add_upd),
    .addend_o  (addend),
    .tick_o    (tick)
  );

  ptp_tod_time #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .DEC_ROLL(DEC_ROLL)
  ) u_time (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .binary_i  (binary),
    .tick_i    (tick),
    .init_i    (cmd.init),
    .update_i  (cmd.update),
    .neg_i     (neg),
    .sec_upd_i (sec_upd),
    .sub_upd_i (sub_upd),
    .incr_i    (incr),
    .sec_o     (sec_o),
    .sub_o     (sub_o)
  );
endmodule

// File: rtl/ptp_tod_counter_chk.sv
module ptp_tod_counter_chk
  import ptp_tod_pkg::*;
#(
  parameter int unsigned SEC_W    = 32,
  parameter int unsigned SUB_W    = 31,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned DEC_ROLL = 1_000_000_000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_addr_i,
  input logic [2:0]       pend,
  input logic             fine,
  input logic             binary,
  input logic [ACC_W-1:0] addend,
  input logic [ACC_W-1:0] add_upd,
  input logic [SEC_W-1:0] sec_upd,
  input logic [SUB_W-1:0] sub_upd,
  input logic [SEC_W-1:0] sec,
  input logic [SUB_W-1:0] sub
);
  localparam logic [SUB_W:0] BIN_R = {1'b1, {SUB_W{1'b0}}};
  localparam logic [SUB_W:0] DEC_R = (SUB_W+1)'(DEC_ROLL);

  assert_cmd_self_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend != 3'b000) && !(wr_en_i && (wr_addr_i == A_CTRL))) |=> (pend == 3'b000));

  assert_init_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[C_INIT] |=> ((sec == $past(sec_upd)) && (sub == $past(sub_upd))));

  assert_addend_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[C_ADDEND] |=> (addend == $past(add_upd)));

  assert_sub_in_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, sub} < (binary ? BIN_R : DEC_R)));

  assert_fine_zero_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fine && (addend == '0) && (pend[C_UPDATE:C_INIT] == 2'b00)) |=> ($stable(sec) && $stable(sub)));

  assert_sec_single_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[C_UPDATE:C_INIT] == 2'b00) |=> ((sec == $past(sec)) || (sec == $past(sec) + 1'b1)));
endmodule

bind ptp_tod_counter ptp_tod_counter_chk #(
  .SEC_W(SEC_W), .SUB_W(SUB_W), .ACC_W(ACC_W), .DEC_ROLL(DEC_ROLL)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .pend      (cmd),
  .fine      (fine),
  .binary    (binary),
  .addend    (addend),
  .add_upd   (add_upd),
  .sec_upd   (sec_upd),
  .sub_upd   (sub_upd),
  .sec       (sec_o),
  .sub       (sub_o)
);

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb;
  import ptp_tod_pkg::*;

  localparam longint TWO32 = 64'h1_0000_0000;
  localparam longint DEC   = 64'd1_000_000_000;
  localparam longint BIN   = 64'h8000_0000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o, sec_o;
  logic [30:0] sub_o;

  always #2 clk_i = ~clk_i;

  ptp_tod_counter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .sec_o(sec_o), .sub_o(sub_o)
  );

  int    errors = 0, checks = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  longint m_sec, m_sub, m_acc, m_add, m_inc, m_secu, m_subu, m_addu, m_shadow;
  bit     m_neg, m_fine, m_bin;
  bit [2:0] m_pend;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint model_read(input logic [2:0] a);
    case (a)
      A_CTRL:    return longint'({m_bin, m_fine, m_pend});
      A_INCR:    return m_inc;
      A_SEC_UPD: return m_secu;
      A_SUB_UPD: return m_subu + (m_neg ? BIN : 0);
      A_ADD_UPD: return m_addu;
      A_SEC:     return m_shadow;
      A_SUB:     return m_sub;
      default:   return m_add;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin : model
    longint roll, s, c;
    bit tick;
    if (!rst_ni) begin
      m_sec = 0; m_sub = 0; m_acc = 0; m_add = 0; m_inc = 0;
      m_secu = 0; m_subu = 0; m_addu = 0; m_shadow = 0;
      m_neg = 0; m_fine = 0; m_bin = 0; m_pend = 0;
    end else begin
      if (rd_en_i && rd_addr_i == A_SUB) m_shadow = m_sec;
      roll = m_bin ? BIN : DEC;
      s = m_acc + m_add;
      tick = m_fine ? (s >= TWO32) : 1'b1;
      m_acc = s % TWO32;
      if (m_pend[0]) begin
        m_sec = m_secu;
        m_sub = m_subu;
      end else if (m_pend[1] || tick) begin
        s = m_sub + (m_pend[1] ? m_subu : m_inc);
        c = (s >= roll) ? 1 : 0;
        if (c != 0) s = s - roll;
        m_sub = s;
        m_sec = (m_sec + (m_pend[1] ? m_secu : 0) + c
                 - ((m_pend[1] && m_neg) ? 1 : 0) + TWO32) % TWO32;
      end
      if (m_pend[2]) m_add = m_addu;
      m_pend = 3'b000;
      if (wr_en_i) begin
        case (wr_addr_i)
          A_CTRL: begin
            m_pend = wr_data_i[2:0];
            m_fine = wr_data_i[3];
            m_bin  = wr_data_i[4];
          end
          A_INCR:    m_inc  = longint'(wr_data_i[30:0]);
          A_SEC_UPD: m_secu = longint'(wr_data_i);
          A_SUB_UPD: begin
            m_subu = longint'(wr_data_i[30:0]);
            m_neg  = wr_data_i[31];
          end
          A_ADD_UPD: m_addu = longint'(wr_data_i);
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison of the live time
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(sec_o == 32'(m_sec), cur_req, "seconds", longint'(sec_o), m_sec);
      check(sub_o == 31'(m_sub), "R11", "sub-seconds", longint'(sub_o), m_sub);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a);
    rd_en_i = 1'b1; rd_addr_i = a;
    #1;
    check(rd_data_o == 32'(model_read(a)), "R10", $sformatf("read addr %0d", a),
          longint'(rd_data_o), model_read(a));
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL all: watchdog expired, actual cycles=100000 expected fewer");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    check(sec_o == 0 && sub_o == 0, "R1", "time after reset", longint'(sub_o), 0);
    rd_chk(A_CTRL);
    check(rd_data_o == 0, "R1", "control after reset", longint'(rd_data_o), 0);
    rd_chk(A_ADDEND);
    rd_chk(A_INCR);

    cur_req = "R7";
    wr(A_INCR, 32'd20);
    idle(10);

    cur_req = "R2";
    wr(A_SEC_UPD, 32'd5);
    wr(A_SUB_UPD, 32'd999_999_900);
    wr(A_CTRL, 32'h1);
    check(rd_data_o[0] == 1'b1 || rd_addr_i != A_CTRL, "R2", "pending init", 0, 1);
    rd_chk(A_CTRL);
    check(sec_o == 32'd5 && sub_o == 31'd999_999_900, "R2", "loaded sub-seconds",
          longint'(sub_o), 999_999_900);
    rd_chk(A_CTRL);
    check(rd_data_o[0] == 1'b0, "R2", "init self-clear", longint'(rd_data_o[0]), 0);

    cur_req = "R8";
    idle(8);

    cur_req = "R3";
    wr(A_SEC_UPD, 32'd3);
    wr(A_SUB_UPD, 32'd999_999_000);
    wr(A_CTRL, 32'h2);
    idle(4);
    wr(A_SUB_UPD, 32'd200);
    wr(A_CTRL, 32'h2);
    idle(3);

    cur_req = "R4";
    wr(A_SEC_UPD, 32'(TWO32 - 2));
    wr(A_SUB_UPD, 32'h8000_0000 | 32'(DEC - 500));
    wr(A_CTRL, 32'h2);
    idle(3);
    wr(A_SEC_UPD, 32'(TWO32 - 1));
    wr(A_SUB_UPD, 32'h8000_0000 | 32'(DEC - 999_999_990));
    wr(A_CTRL, 32'h2);
    idle(3);

    cur_req = "R6";
    wr(A_SEC_UPD, 32'd100);
    wr(A_SUB_UPD, 32'd7);
    wr(A_ADD_UPD, 32'h8000_0000);
    wr(A_CTRL, 32'h7);
    idle(1);
    check(sec_o == 32'd100 && sub_o == 31'd7, "R6", "init wins over update",
          longint'(sec_o), 100);
    rd_chk(A_ADDEND);
    check(rd_data_o == 32'h8000_0000, "R5", "addend loaded", longint'(rd_data_o), BIN);

    cur_req = "R9";
    wr(A_CTRL, 32'h8);
    idle(20);
    cur_req = "R5";
    wr(A_ADD_UPD, 32'h4000_0000);
    wr(A_CTRL, 32'hC);
    idle(20);
    cur_req = "R9";
    wr(A_ADD_UPD, 32'h0);
    wr(A_CTRL, 32'hC);
    idle(10);

    cur_req = "R10";
    wr(A_CTRL, 32'h0);
    wr(A_SEC_UPD, 32'd50);
    wr(A_SUB_UPD, 32'(DEC - 70));
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 6; i++) begin
      rd_chk(A_SUB);
      rd_chk(A_SEC);
    end
    for (int a = 0; a < 8; a++) rd_chk(3'(a));

    cur_req = "R8";
    wr(A_SEC_UPD, 32'hFFFF_FFFF);
    wr(A_SUB_UPD, 32'(BIN - 50));
    wr(A_CTRL, 32'h11);
    idle(6);
    check(sec_o == 32'd0, "R8", "binary wrap of seconds", longint'(sec_o), 0);

    cur_req = "R3";
    wr(A_SEC_UPD, 32'd1);
    wr(A_SUB_UPD, 32'(BIN - 1));
    wr(A_CTRL, 32'h12);
    idle(3);

    cur_req = "R9";
    wr(A_ADD_UPD, 32'hC000_0000);
    wr(A_CTRL, 32'h1C);
    idle(20);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule